// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This execution unit computes the signed small-operand multiply forms of a processor datapath. Each 32-bit source word offers either its upper or its lower 16-bit half as a signed factor. The unit covers five operations: a plain 16x16 product, a 16x16 product added to one accumulator word, a 16x16 product added to a 64-bit accumulator held in a high/low register pair, a 32x16 product keeping the middle 32 bits of the 48-bit result, and that middle-bits product added to one accumulator word.

The two single-word accumulate forms report signed overflow of the addition as a request to set the sticky saturation flag. The wrapped sum is still written, and clearing the flag is done elsewhere. The unit touches no other condition flags. A failed condition still returns a result beat, but with every write enable and the flag request low. The 64-bit form also reports an unpredictable encoding when its two destination indices are equal.

Operations enter on a valid/ready input stream and leave on a valid/ready output stream through one register stage. The input is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. A result held while `out_ready` is low stays unchanged until it is taken.

Top module: `hmul_unit`

## Requirements
- R1: A select bit of 1 uses bits 31:16 of its source word as the signed factor, and a select bit of 0 uses bits 15:0, sign-extended.
- R2: Operation code 0 (plain 16x16) delivers the 32-bit product on `out_lo` with `out_we_lo`=1, `out_we_hi`=0 and never requests the flag.
- R3: Operation code 1 delivers the product plus `in_acc_lo`, wrapped to 32 bits, on `out_lo`, with `out_we_lo`=1. It raises `out_q_set` exactly when that signed addition overflows.
- R4: Operation code 2 adds the product, sign-extended to 64 bits, to {`in_acc_hi`,`in_acc_lo`}. It delivers the low word on `out_lo` and the high word on `out_hi`, with both write enables at 1 and never a flag request.
- R5: Operation code 3 multiplies all of `in_opn` (signed) by the selected signed half of `in_opm`, and delivers bits 47:16 of the 48-bit product on `out_lo` with `out_we_lo`=1. `in_top_n` has no effect on it.
- R6: Operation code 4 adds the code-3 value to `in_acc_lo` and delivers the wrapped sum, raising `out_q_set` exactly on signed overflow of that addition.
- R7: An operation accepted with `in_cond_ok`=0 still produces one output beat, but with `out_we_lo`, `out_we_hi` and `out_q_set` all 0.
- R8: `out_unpred` is 1 on a beat from operation code 2 whose `in_dst_lo` equals `in_dst_hi`, independent of `in_cond_ok`, and 0 on every other beat.
- R9: After reset `out_valid` is 0 and `in_ready` is 1. An accepted operation appears with `out_valid`=1 on the next cycle. A beat held with `out_ready`=0 keeps all its output values.
- R10: Operation codes 5, 6 and 7 produce a beat with both write enables and `out_q_set` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operation valid |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_op | input | 3 | Operation code (0..4 defined, 5..7 reserved) |
| in_top_n | input | 1 | Half select for the first operand |
| in_top_m | input | 1 | Half select for the second operand |
| in_opn | input | WORD | First operand word |
| in_opm | input | WORD | Second operand word |
| in_acc_lo | input | WORD | Accumulator word / low word of the pair |
| in_acc_hi | input | WORD | High word of the accumulator pair |
| in_cond_ok | input | 1 | Condition passed |
| in_dst_lo | input | IDXW | Destination index of the low word |
| in_dst_hi | input | IDXW | Destination index of the high word |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_lo | output | WORD | Result word / low word of the pair |
| out_hi | output | WORD | High word of the pair |
| out_we_lo | output | 1 | Write enable for the low destination |
| out_we_hi | output | 1 | Write enable for the high destination |
| out_q_set | output | 1 | Request to set the sticky saturation flag |
| out_unpred | output | 1 | Unpredictable destination pairing |

## Verification
Two things can fall in the same cycle: a result beat leaving the output register, and the next operation being accepted into it. The same holds when the leaving beat carries a flag request that an operation with no flag request replaces. The bench provokes both by switching `out_ready` on a pattern of stall cycles while the driver keeps `in_valid` high. It puts overflowing accumulate forms next to plain forms. A scoreboard judges each beat against its own model of the operation, in order, so a lost, duplicated or stale beat, or a flag that lingers, is reported. A separate check compares each held beat with the values it had when the stall began.

// File: rtl/hmul_pkg.sv
package hmul_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_MUL16 = 3'd0,
    OP_MAC32 = 3'd1,
    OP_MAC64 = 3'd2,
    OP_MULW  = 3'd3,
    OP_MACW  = 3'd4
  } hmul_op_e;
endpackage

// File: rtl/hmul_halfsel.sv
module hmul_halfsel #(
  parameter int WORD = 32
) (
  input  logic [WORD-1:0]        word_i,
  input  logic                   top_i,
  output logic signed [WORD-1:0] half_o
);
  localparam int HALF = WORD / 2;

  logic [HALF-1:0] pick;

  // upper half behaves as an arithmetic shift right by HALF
  assign pick   = top_i ? word_i[WORD-1:HALF] : word_i[HALF-1:0];
  assign half_o = {{(WORD-HALF){pick[HALF-1]}}, pick};
endmodule

// File: rtl/hmul_product.sv
module hmul_product #(
  parameter int WORD = 32
) (
  input  logic signed [WORD-1:0] hn_i,
  input  logic signed [WORD-1:0] hm_i,
  input  logic [WORD-1:0]        word_n_i,
  output logic [WORD-1:0]        hh_o,
  output logic [WORD-1:0]        wh_o
);
  localparam int HALF = WORD / 2;
  localparam int WIDE = WORD + HALF;

  logic signed [WORD-1:0] hh_full;
  logic signed [WIDE-1:0] wn_ext;
  logic signed [WIDE-1:0] wm_ext;
  logic signed [WIDE-1:0] wide_p;
  logic [HALF-1:0]        frac_unused;

  // half x half always fits in one word
  assign hh_full = hn_i * hm_i;
  assign hh_o    = hh_full;

  // word x half: keep the middle word of the product
  assign wn_ext = {{HALF{word_n_i[WORD-1]}}, word_n_i};
  assign wm_ext = {{HALF{hm_i[WORD-1]}}, hm_i};
  assign wide_p = wn_ext * wm_ext;
  assign {wh_o, frac_unused} = wide_p;
endmodule

// File: rtl/hmul_accum.sv
module hmul_accum #(
  parameter int WORD = 32
) (
  input  logic [WORD-1:0] add_i,
  input  logic [WORD-1:0] prod_i,
  input  logic [WORD-1:0] acc_lo_i,
  input  logic [WORD-1:0] acc_hi_i,
  output logic [WORD-1:0] sum_o,
  output logic            ovf_o,
  output logic [WORD-1:0] pair_lo_o,
  output logic [WORD-1:0] pair_hi_o
);
  localparam int DBL = 2 * WORD;

  logic [DBL-1:0] prod_ext;
  logic [DBL-1:0] pair_sum;

  // single-word add, signed overflow when like signs give an unlike sum
  assign sum_o = add_i + acc_lo_i;
  assign ovf_o = (add_i[WORD-1] == acc_lo_i[WORD-1]) &&
                 (sum_o[WORD-1] != add_i[WORD-1]);

  // double-word add of the sign-extended product
  assign prod_ext  = {{WORD{prod_i[WORD-1]}}, prod_i};
  assign pair_sum  = prod_ext + {acc_hi_i, acc_lo_i};
  assign pair_lo_o = pair_sum[WORD-1:0];
  assign pair_hi_o = pair_sum[DBL-1:WORD];
endmodule

// File: rtl/hmul_unit.sv
module hmul_unit
  import hmul_pkg::*;
#(
  parameter int WORD = 32,
  parameter int IDXW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic              in_top_n,
  input  logic              in_top_m,
  input  logic [WORD-1:0]   in_opn,
  input  logic [WORD-1:0]   in_opm,
  input  logic [WORD-1:0]   in_acc_lo,
  input  logic [WORD-1:0]   in_acc_hi,
  input  logic              in_cond_ok,
  input  logic [IDXW-1:0]   in_dst_lo,
  input  logic [IDXW-1:0]   in_dst_hi,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD-1:0]   out_lo,
  output logic [WORD-1:0]   out_hi,
  output logic              out_we_lo,
  output logic              out_we_hi,
  output logic              out_q_set,
  output logic              out_unpred
);
  localparam int NSRC = 2;

  logic [WORD-1:0]        src_w  [NSRC];
  logic                   src_t  [NSRC];
  logic signed [WORD-1:0] half_w [NSRC];

  assign src_w[0] = in_opn;
  assign src_w[1] = in_opm;
  assign src_t[0] = in_top_n;
  assign src_t[1] = in_top_m;

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_sel
    hmul_halfsel #(.WORD(WORD)) u_sel (
      .word_i (src_w[gi]),
      .top_i  (src_t[gi]),
      .half_o (half_w[gi])
    );
  end

  logic [WORD-1:0] prod_hh;
  logic [WORD-1:0] prod_wh;

  hmul_product #(.WORD(WORD)) u_prod (
    .hn_i     (half_w[0]),
    .hm_i     (half_w[1]),
    .word_n_i (in_opn),
    .hh_o     (prod_hh),
    .wh_o     (prod_wh)
  );

  logic [WORD-1:0] acc_add;
  logic [WORD-1:0] sum_w;
  logic            sum_ovf;
  logic [WORD-1:0] pair_lo;
  logic [WORD-1:0] pair_hi;

  assign acc_add = (in_op == OP_MACW) ? prod_wh : prod_hh;

  hmul_accum #(.WORD(WORD)) u_acc (
    .add_i     (acc_add),
    .prod_i    (prod_hh),
    .acc_lo_i  (in_acc_lo),
    .acc_hi_i  (in_acc_hi),
    .sum_o     (sum_w),
    .ovf_o     (sum_ovf),
    .pair_lo_o (pair_lo),
    .pair_hi_o (pair_hi)
  );

  logic [WORD-1:0] nx_lo;
  logic [WORD-1:0] nx_hi;
  logic            nx_we_lo;
  logic            nx_we_hi;
  logic            nx_q;
  logic            nx_unpred;

  always_comb begin
    nx_lo    = '0;
    nx_hi    = '0;
    nx_we_lo = 1'b0;
    nx_we_hi = 1'b0;
    nx_q     = 1'b0;
    case (in_op)
      OP_MUL16: begin
        nx_lo    = prod_hh;
        nx_we_lo = 1'b1;
      end
      OP_MAC32, OP_MACW: begin
        nx_lo    = sum_w;
        nx_we_lo = 1'b1;
        nx_q     = sum_ovf;
      end
      OP_MAC64: begin
        nx_lo    = pair_lo;
        nx_hi    = pair_hi;
        nx_we_lo = 1'b1;
        nx_we_hi = 1'b1;
      end
      OP_MULW: begin
        nx_lo    = prod_wh;
        nx_we_lo = 1'b1;
      end
      default: ;
    endcase
    if (!in_cond_ok) begin
      nx_we_lo = 1'b0;
      nx_we_hi = 1'b0;
      nx_q     = 1'b0;
    end
  end

  assign nx_unpred = (in_op == OP_MAC64) && (in_dst_lo == in_dst_hi);

  logic take_in;
  assign in_ready = !out_valid || out_ready;
  assign take_in  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_lo     <= '0;
      out_hi     <= '0;
      out_we_lo  <= 1'b0;
      out_we_hi  <= 1'b0;
      out_q_set  <= 1'b0;
      out_unpred <= 1'b0;
    end else if (take_in) begin
      out_valid  <= 1'b1;
      out_lo     <= nx_lo;
      out_hi     <= nx_hi;
      out_we_lo  <= nx_we_lo;
      out_we_hi  <= nx_we_hi;
      out_q_set  <= nx_q;
      out_unpred <= nx_unpred;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
      out_we_lo  <= 1'b0;
      out_we_hi  <= 1'b0;
      out_q_set  <= 1'b0;
      out_unpred <= 1'b0;
    end
  end
endmodule

// File: rtl/hmul_unit_chk.sv
module hmul_unit_chk
  import hmul_pkg::*;
#(
  parameter int WORD = 32,
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [OP_W-1:0] in_op,
  input logic            in_cond_ok,
  input logic [IDXW-1:0] in_dst_lo,
  input logic [IDXW-1:0] in_dst_hi,
  input logic            out_valid,
  input logic            out_ready,
  input logic [WORD-1:0] out_lo,
  input logic [WORD-1:0] out_hi,
  input logic            out_we_lo,
  input logic            out_we_hi,
  input logic            out_q_set,
  input logic            out_unpred
);
  logic acc_beat;
  assign acc_beat = in_valid && in_ready;

  // R9
  accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_beat |=> out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lo) && $stable(out_hi) &&
      $stable(out_we_lo) && $stable(out_we_hi) && $stable(out_q_set) && $stable(out_unpred)));

  // R2
  plain_no_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_beat && in_op == OP_MUL16) |=> !out_q_set);

  // R4
  pair_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_beat && in_op == OP_MAC64 && in_cond_ok) |=> (out_we_lo && out_we_hi && !out_q_set));

  // R7
  cond_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_beat && !in_cond_ok) |=> (out_valid && !out_we_lo && !out_we_hi && !out_q_set));

  // R10
  rsv_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_beat && in_op > OP_MACW) |=> (!out_we_lo && !out_we_hi && !out_q_set));

  // R3
  q_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_q_set |-> (out_valid && out_we_lo && !out_we_hi));

  // R8
  unpred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_beat |=> (out_unpred == $past(in_op == OP_MAC64 && in_dst_lo == in_dst_hi)));
endmodule

bind hmul_unit hmul_unit_chk #(.WORD(WORD), .IDXW(IDXW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_cond_ok (in_cond_ok),
  .in_dst_lo  (in_dst_lo),
  .in_dst_hi  (in_dst_hi),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_lo     (out_lo),
  .out_hi     (out_hi),
  .out_we_lo  (out_we_lo),
  .out_we_hi  (out_we_hi),
  .out_q_set  (out_q_set),
  .out_unpred (out_unpred)
);

// File: tb/hmul_unit_bench.sv
module hmul_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic        in_top_n = 1'b0;
  logic        in_top_m = 1'b0;
  logic [31:0] in_opn = '0;
  logic [31:0] in_opm = '0;
  logic [31:0] in_acc_lo = '0;
  logic [31:0] in_acc_hi = '0;
  logic        in_cond_ok = 1'b1;
  logic [3:0]  in_dst_lo = '0;
  logic [3:0]  in_dst_hi = 4'd1;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_lo;
  logic [31:0] out_hi;
  logic        out_we_lo;
  logic        out_we_hi;
  logic        out_q_set;
  logic        out_unpred;

  hmul_unit u_hmul_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_top_n(in_top_n), .in_top_m(in_top_m),
    .in_opn(in_opn), .in_opm(in_opm), .in_acc_lo(in_acc_lo), .in_acc_hi(in_acc_hi),
    .in_cond_ok(in_cond_ok), .in_dst_lo(in_dst_lo), .in_dst_hi(in_dst_hi),
    .out_valid(out_valid), .out_ready(out_ready), .out_lo(out_lo), .out_hi(out_hi),
    .out_we_lo(out_we_lo), .out_we_hi(out_we_hi), .out_q_set(out_q_set),
    .out_unpred(out_unpred)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [31:0] lo;
    logic [31:0] hi;
    logic        we_lo;
    logic        we_hi;
    logic        q;
    logic        unpred;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  bit    mon_on = 1'b0;
  int    stall_phase = 0;
  int    rcyc = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // independent model of every operation
  function automatic exp_t model(input logic [2:0] op, input logic tn, input logic tm,
                                 input logic [31:0] n, input logic [31:0] m,
                                 input logic [31:0] alo, input logic [31:0] ahi,
                                 input logic cond, input logic [3:0] il, input logic [3:0] ih);
    exp_t e;
    longint a, b, p, wp, s;
    logic [63:0] w64;
    logic [31:0] wr;
    e = '0;
    a = tn ? longint'($signed(n[31:16])) : longint'($signed(n[15:0]));
    b = tm ? longint'($signed(m[31:16])) : longint'($signed(m[15:0]));
    p = a * b;
    wp = longint'($signed(n)) * b;
    wr = wp[47:16];
    case (op)
      3'd0: begin e.lo = p[31:0]; e.we_lo = 1'b1; end
      3'd1: begin
        s = p + longint'($signed(alo));
        e.lo = s[31:0]; e.we_lo = 1'b1; e.q = s[32] ^ s[31];
      end
      3'd2: begin
        w64 = p + {ahi, alo};
        e.lo = w64[31:0]; e.hi = w64[63:32]; e.we_lo = 1'b1; e.we_hi = 1'b1;
      end
      3'd3: begin e.lo = wr; e.we_lo = 1'b1; end
      3'd4: begin
        s = longint'($signed(wr)) + longint'($signed(alo));
        e.lo = s[31:0]; e.we_lo = 1'b1; e.q = s[32] ^ s[31];
      end
      default: ;
    endcase
    if (!cond) begin e.we_lo = 1'b0; e.we_hi = 1'b0; e.q = 1'b0; end
    e.unpred = (op == 3'd2) && (il == ih);
    return e;
  endfunction

  // driver: present one operation, push its expectation on acceptance
  task automatic send(input string tag, input logic [2:0] op, input logic tn, input logic tm,
                      input logic [31:0] n, input logic [31:0] m,
                      input logic [31:0] alo, input logic [31:0] ahi,
                      input logic cond, input logic [3:0] il, input logic [3:0] ih);
    bit took;
    @(negedge clk);
    in_op = op; in_top_n = tn; in_top_m = tm; in_opn = n; in_opm = m;
    in_acc_lo = alo; in_acc_hi = ahi; in_cond_ok = cond; in_dst_lo = il; in_dst_hi = ih;
    in_valid = 1'b1;
    took = 1'b0;
    while (!took) begin
      if (in_ready) took = 1'b1;
      @(posedge clk);
      if (!took) @(negedge clk);
    end
    expq.push_back(model(op, tn, tm, n, m, alo, ahi, cond, il, ih));
    tagq.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // back-pressure pattern, settled well before the falling edge
  always @(posedge clk) begin
    #1;
    rcyc++;
    if (stall_phase == 0) out_ready = 1'b1;
    else out_ready = !((rcyc % 5) == 2 || (rcyc % 7) == 3);
  end

  // monitor: compare each beat leaving the unit; check held beats
  logic        held = 1'b0;
  logic [31:0] h_lo, h_hi;
  logic [3:0]  h_fl;
  always @(negedge clk) begin
    if (mon_on) begin
      if (held && out_valid) begin
        check("R9", "held beat lo", out_lo, h_lo);
        check("R9", "held beat flags", {28'd0, out_we_lo, out_we_hi, out_q_set, out_unpred},
              {28'd0, h_fl});
      end
      held = out_valid && !out_ready;
      h_lo = out_lo; h_hi = out_hi;
      h_fl = {out_we_lo, out_we_hi, out_q_set, out_unpred};
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check("R9", "unexpected beat", 32'd1, 32'd0);
        end else begin
          exp_t  e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(t, "we_lo", {31'd0, out_we_lo}, {31'd0, e.we_lo});
          check(t, "we_hi", {31'd0, out_we_hi}, {31'd0, e.we_hi});
          check(t, "q_set", {31'd0, out_q_set}, {31'd0, e.q});
          check(t, "unpred", {31'd0, out_unpred}, {31'd0, e.unpred});
          if (e.we_lo) check(t, "lo", out_lo, e.lo);
          if (e.we_hi) check(t, "hi", out_hi, e.hi);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog expired: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R9", "reset in_ready", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R1 half selection in both directions
    send("R1", 3'd0, 1'b0, 1'b1, 32'h1234_FFFE, 32'h0003_8000, 0, 0, 1'b1, 4'd0, 4'd1);
    send("R1", 3'd0, 1'b1, 1'b0, 32'h8000_0007, 32'hFFFF_7FFF, 0, 0, 1'b1, 4'd0, 4'd1);
    // R2 plain product, most negative squared
    send("R2", 3'd0, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_8000, 32'h7FFF_FFFF, 0, 1'b1, 4'd2, 4'd3);
    // R3 positive overflow, negative overflow, no overflow
    send("R3", 3'd1, 1'b0, 1'b0, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 0, 1'b1, 4'd0, 4'd1);
    send("R3", 3'd1, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_7FFF, 32'h8000_0000, 0, 1'b1, 4'd0, 4'd1);
    send("R3", 3'd1, 1'b0, 1'b1, 32'h0000_0010, 32'hFFFF_0000, 32'h0000_0100, 0, 1'b1, 4'd0, 4'd1);
    // R4 pair with carry, and borrow through the whole pair
    send("R4", 3'd2, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_8000, 32'hC000_0000, 32'h0, 1'b1, 4'd4, 4'd5);
    send("R4", 3'd2, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_0001, 32'h0, 32'h0, 1'b1, 4'd4, 4'd5);
    // R5 middle bits, and the first select bit has no effect
    send("R5", 3'd3, 1'b0, 1'b0, 32'h8000_0000, 32'h0000_8000, 0, 0, 1'b1, 4'd0, 4'd1);
    send("R5", 3'd3, 1'b1, 1'b1, 32'h8000_0000, 32'h8000_1234, 0, 0, 1'b1, 4'd0, 4'd1);
    send("R5", 3'd3, 1'b0, 1'b1, 32'h1234_5678, 32'hFFF0_0000, 0, 0, 1'b1, 4'd0, 4'd1);
    // R6 overflow and no overflow
    send("R6", 3'd4, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 0, 1'b1, 4'd0, 4'd1);
    send("R6", 3'd4, 1'b0, 1'b0, 32'h0001_0000, 32'h0000_0003, 32'h0000_0005, 0, 1'b1, 4'd0, 4'd1);
    // R7 overflowing accumulate and pair form with condition failed
    send("R7", 3'd1, 1'b0, 1'b0, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 0, 1'b0, 4'd0, 4'd1);
    send("R7", 3'd2, 1'b0, 1'b0, 32'h0000_0003, 32'h0000_0003, 32'h1, 32'h2, 1'b0, 4'd0, 4'd1);
    // R8 equal indices: pair form flags, even with condition failed; single form does not
    send("R8", 3'd2, 1'b0, 1'b0, 32'h0000_0002, 32'h0000_0002, 0, 0, 1'b1, 4'd7, 4'd7);
    send("R8", 3'd2, 1'b0, 1'b0, 32'h0000_0002, 32'h0000_0002, 0, 0, 1'b0, 4'd9, 4'd9);
    send("R8", 3'd1, 1'b0, 1'b0, 32'h0000_0002, 32'h0000_0002, 0, 0, 1'b1, 4'd7, 4'd7);
    // R10 reserved codes
    send("R10", 3'd5, 1'b0, 1'b0, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 0, 1'b1, 4'd0, 4'd1);
    send("R10", 3'd6, 1'b1, 1'b1, 32'h7FFF_0000, 32'h7FFF_0000, 32'h7FFF_FFFF, 0, 1'b1, 4'd3, 4'd3);
    send("R10", 3'd7, 1'b0, 1'b0, 32'h1, 32'h1, 0, 0, 1'b1, 4'd0, 4'd1);

    // R9 back-pressure with a mixed stream, overflow beats next to plain ones
    stall_phase = 1;
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      send("R9", op, 1'($urandom), 1'($urandom), $urandom, $urandom,
           ((i % 3) == 0) ? 32'h7FFF_FFF0 : $urandom, $urandom,
           ($urandom_range(0, 9) != 0), 4'($urandom_range(0, 3)), 4'($urandom_range(0, 3)));
      if ((i % 11) == 5) idle();
    end
    idle();

    while (expq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule